// File: doc/BRIEF.md
# Flag-Delimited Byte-Stuffed Frame Receiver

This block sits behind a UART byte receiver and turns its stream of bytes into checked frames. A frame opens and closes on the flag byte 0x7E. A flag or escape value carried inside a frame is sent as the escape byte 0x7D followed by the value XORed with 0x20. The last unescaped byte of each frame is a CRC-8 over the payload. The receiver strips the framing, undoes the escapes and runs the CRC over every recovered byte. It stores the recovered bytes in a small internal buffer.

When a closing flag arrives with a zero CRC residue and a legal length, the block raises `frame_ready`. It also presents the payload length, with the CRC byte left out. A consumer reads the payload through an address/data read port. Further input is dropped until the consumer pulses `restart`, which sends the block back to hunting for an opening flag.

Illegal escape pairs and oversized frames are discarded. A closing flag that fails its checks is reused as the opening flag of the next frame.

Top module: `stuffed_frame_rx`

## Requirements
- R1: After reset the receiver waits for an opening flag and `frame_ready` is 0.
- R2: While waiting, every byte other than 0x7E is ignored. A 0x7E starts a frame with a cleared count and a CRC preset of 0xFF.
- R3: The CRC is CRC-8 with reflected polynomial 0x8C (x^8+x^5+x^4+1). It is processed LSB first, with a 0xFF preset and no final XOR, over every recovered byte including the trailing CRC byte. A frame is accepted only if the residue is 0. The sequence 7E 01 00 00 01 3A 7E is accepted with payload 01 00 00 01.
- R4: Inside a frame, 0x7D followed by byte X stores X XOR 0x20. Neither the 0x7D nor the raw X is stored.
- R5: On acceptance `frame_ready` is 1 and `frame_len` equals the number of stored bytes minus one. Payload byte i (the i-th recovered byte, from 0) is readable at `rd_addr` = i.
- R6: A closing flag that fails the CRC or length check opens a new frame at once. The bytes that follow, up to the next flag, are judged as a fresh frame.
- R7: 0x7D directly after an escape byte aborts the frame. The block then ignores bytes until the next 0x7E.
- R8: 0x7E directly after an escape byte abandons the frame and opens a new one.
- R9: A byte that arrives when MAX_LEN+1 bytes are already stored aborts the frame back to waiting. A frame of exactly MAX_LEN payload bytes plus CRC is accepted.
- R10: A frame with fewer than MIN_LEN payload bytes is rejected even when its CRC is correct.
- R11: While `frame_ready` is 1, incoming bytes are dropped and the length and buffer stay unchanged. A `restart` pulse returns the block to waiting in the next cycle and takes priority over a byte presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | 8 | Received byte |
| restart | input | 1 | Release a held frame and hunt for a new opening flag |
| frame_ready | output | 1 | A checked frame is held in the buffer |
| frame_len | output | $clog2(MAX_LEN+2) | Payload length of the held frame, CRC excluded |
| rd_addr | input | $clog2(MAX_LEN+1) | Buffer read address |
| rd_data | output | 8 | Buffer byte at `rd_addr` |

## Verification
The bench uses flag and escape values inside the payload, in the CRC byte, and directly after an escape. A receiver that stored the raw escaped value, or closed the frame on an escaped flag, would return a wrong payload or a short frame. It sends frames at exactly the maximum length, one byte over it, and one byte under the minimum. An off-by-one in the count limits would then accept a frame it must drop, or drop one it must keep. It sends a failed frame whose closing flag is directly followed by a good frame, and a double escape followed by a well-formed body. These catch a design that mishandles flag reuse or abort recovery, since either would accept the wrong frame. While a frame is held, it sends a new frame and pulses restart together with a flag, so that overwriting the buffer or taking the flag before the restart both show.

// File: rtl/stuffed_frame_rx.sv
module stuffed_frame_rx #(
  parameter int MIN_LEN = 23,
  parameter int MAX_LEN = 38,
  localparam int CNT_W = $clog2(MAX_LEN + 2),
  localparam int AW = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             restart,
  output logic             frame_ready,
  output logic [CNT_W-1:0] frame_len,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data
);
  localparam int DEPTH = MAX_LEN + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] LOW  = CNT_W'(MIN_LEN + 1);
  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [7:0] ESC  = 8'h7D;

  typedef enum logic [1:0] {S_WAIT, S_READY, S_PKT, S_ESC} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       crc;
  logic [7:0]       mem [DEPTH];

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    return r;
  endfunction

  logic       is_flag, is_esc, in_frame, take;
  logic [7:0] byte_val;

  assign is_flag  = in_data == FLAG;
  assign is_esc   = in_data == ESC;
  assign in_frame = state == S_PKT || state == S_ESC;
  assign byte_val = (state == S_ESC) ? (in_data ^ 8'h20) : in_data;
  assign take     = in_valid && !restart && in_frame && !is_flag && !is_esc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_WAIT;
      cnt   <= '0;
      crc   <= 8'hFF;
    end else if (restart) begin
      state <= S_WAIT;
    end else if (in_valid) begin
      unique case (state)
        S_WAIT: if (is_flag) begin
          cnt   <= '0;
          crc   <= 8'hFF;
          state <= S_PKT;
        end
        S_READY: ;
        S_PKT, S_ESC: begin
          if (is_esc) begin
            state <= (state == S_PKT) ? S_ESC : S_WAIT;
          end else if (is_flag) begin
            if (state == S_PKT && crc == 8'h00 && cnt >= LOW) begin
              cnt   <= cnt - 1'b1;
              state <= S_READY;
            end else begin
              cnt   <= '0;
              crc   <= 8'hFF;
              state <= S_PKT;
            end
          end else begin
            crc <= crc_step(crc, byte_val);
            if (cnt >= FULL) begin
              state <= S_WAIT;
            end else begin
              cnt   <= cnt + 1'b1;
              state <= S_PKT;
            end
          end
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (take && cnt < FULL) mem[cnt[AW-1:0]] <= byte_val;

  assign frame_ready = state == S_READY;
  assign frame_len   = cnt;
  assign rd_data     = (rd_addr <= AW'(DEPTH - 1)) ? mem[rd_addr] : 8'h00;

  // R5
  ready_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (frame_len >= CNT_W'(MIN_LEN) && frame_len <= CNT_W'(MAX_LEN)));
  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  // R11
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READY && !restart) |=> (state == S_READY && $stable(cnt)));
  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> state == S_WAIT);
  // R2
  open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && in_valid && in_data == FLAG && !restart)
      |=> (state == S_PKT && cnt == '0 && crc == 8'hFF));
  // R7
  esc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ESC && in_valid && in_data == ESC && !restart) |=> state == S_WAIT);
endmodule

// File: tb/stuffed_frame_rx_tb.sv
module stuffed_frame_rx_tb;
  localparam int MIN_LEN = 4;
  localparam int MAX_LEN = 10;
  localparam int CNT_W = $clog2(MAX_LEN + 2);
  localparam int AW = $clog2(MAX_LEN + 1);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, restart = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic frame_ready;
  logic [CNT_W-1:0] frame_len;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] pay [16];

  // {expect_ok, bad_crc, 2'b0, len[3:0], payload bytes, byte 0 lowest}
  localparam logic [103:0] VEC [7] = '{
    {4'b1000, 4'd4,  96'h44332211},
    {4'b1000, 4'd4,  96'h5D207D7E},
    {4'b1000, 4'd10, 96'h0A09_0807_0605_0403_0201},
    {4'b0000, 4'd11, 96'h0B_0A09_0807_0605_0403_0201},
    {4'b0000, 4'd3,  96'h333231},
    {4'b0100, 4'd4,  96'h44332211},
    {4'b1000, 4'd5,  96'h7DFF007EA5}
  };

  stuffed_frame_rx #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .restart(restart), .frame_ready(frame_ready), .frame_len(frame_len),
    .rd_addr(rd_addr), .rd_data(rd_data));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    return r;
  endfunction

  task automatic raw(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stuffed(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin raw(8'h7D); raw(b ^ 8'h20); end
    else raw(b);
  endtask

  task automatic body(input int n, input bit bad);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin c = crc8(c, pay[i]); stuffed(pay[i]); end
    stuffed(bad ? (c ^ 8'h01) : c);
  endtask

  task automatic frame(input int n, input bit bad);
    raw(8'h7E); body(n, bad); raw(8'h7E);
  endtask

  task automatic pulse_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic check_payload(input string req, input int n);
    check(req, frame_len, n);
    for (int i = 0; i < n; i++) begin
      rd_addr = AW'(i); #1;
      check(req, rd_data, pay[i]);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready after reset", frame_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready idle", frame_ready, 0);

    for (int v = 0; v < 7; v++) begin
      logic [103:0] e = VEC[v];
      for (int i = 0; i < 12; i++) pay[i] = e[8*i +: 8];
      frame(int'(e[99:96]), e[102]);
      check($sformatf("R5/R3/R4/R9/R10 vec%0d ready", v), frame_ready, int'(e[103]));
      if (e[103]) check_payload($sformatf("R5/R4 vec%0d", v), int'(e[99:96]));
      pulse_restart();
      check("R11 restart clears", frame_ready, 0);
    end

    // R3 known frame
    pay[0] = 8'h01; pay[1] = 8'h00; pay[2] = 8'h00; pay[3] = 8'h01;
    raw(8'h7E); raw(8'h01); raw(8'h00); raw(8'h00); raw(8'h01); raw(8'h3A); raw(8'h7E);
    check("R3 known frame ready", frame_ready, 1);
    check_payload("R3 known frame", 4);

    // R11 held frame ignores a new frame
    frame(4, 1'b0);
    pay[0] = 8'hAA; pay[1] = 8'hBB; pay[2] = 8'hCC; pay[3] = 8'hDD;
    frame(4, 1'b0);
    check("R11 still ready", frame_ready, 1);
    check("R11 len held", frame_len, 4);
    rd_addr = '0; #1;
    check("R11 buffer held", rd_data, 8'h01);

    // R11 restart beats a same-cycle flag
    restart = 1'b1; in_valid = 1'b1; in_data = 8'h7E;
    @(negedge clk);
    restart = 1'b0; in_valid = 1'b0;
    raw(8'h01); raw(8'h00); raw(8'h00); raw(8'h01); raw(8'h3A); raw(8'h7E);
    check("R11 restart priority", frame_ready, 0);
    pulse_restart();

    // R2 bytes before an opening flag are ignored
    pay[0] = 8'h10; pay[1] = 8'h20; pay[2] = 8'h30; pay[3] = 8'h40;
    body(4, 1'b0); raw(8'h7E);
    check("R2 no open flag", frame_ready, 0);
    pulse_restart();

    // R6 failed close flag reopens
    raw(8'h7E); body(4, 1'b1); raw(8'h7E); body(4, 1'b0); raw(8'h7E);
    check("R6 reopened ready", frame_ready, 1);
    check_payload("R6 reopened", 4);
    pulse_restart();

    // R7 double escape aborts
    raw(8'h7E); raw(8'h11); raw(8'h7D); raw(8'h7D); body(4, 1'b0); raw(8'h7E);
    check("R7 abort", frame_ready, 0);
    pulse_restart();

    // R8 escape then flag restarts
    raw(8'h7E); raw(8'h11); raw(8'h22); raw(8'h7D); raw(8'h7E); body(4, 1'b0); raw(8'h7E);
    check("R8 new frame ready", frame_ready, 1);
    check_payload("R8 new frame", 4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule